// File: doc/BRIEF.md
# Block Address Translation Register Set

This block holds the block-translation entries of a processor memory unit: a
bank of entry pairs for instruction fetches and an independent bank for data
accesses. Each pair has an upper word (effective base, block-length field,
supervisor-valid and user-valid bits) and a lower word (physical base,
attribute bits and a two-bit protection field). Software-visible register
writes arrive as one command per cycle that names the side, the word and the
entry.

Writing an upper word does more than store a value. A length mask is derived
from the block-length field. It clears the covered bits from the stored
effective base and also from the physical base already held in the paired
lower word. Each side has a combinational lookup. Given an effective address
and the privilege mode, it reports whether any entry covers the address, which
entry won, the translated physical address and the protection field.

Top module: `blkxlat_regs`

## Requirements
- R1: After reset every upper and lower word on both sides is zero, so both lookups report a miss.
- R2: A write to a lower word (`wr_upper`=0) stores `wr_data` unchanged.
- R3: A write to an upper word derives mask = (`wr_data` << 15) & 0x0FFE0000 (block-length field in bits 12:2). It stores bits 12:0 of the value, plus bits 31:17 of the value that are outside the mask. Bits 16:13 and the masked bits read as zero.
- R4: The same upper write rewrites the paired lower word of that side and entry. Bits selected by 0x7B and bits 31:17 outside the mask keep their old value. Every other bit becomes zero.
- R5: An upper write whose value equals the stored upper word leaves both the upper and the lower word of that entry unchanged.
- R6: Instruction-side (`wr_side`=0) and data-side (`wr_side`=1) entries are independent. A write to one side never changes the other side's lookup.
- R7: An entry hits when effective-address bits 31:17, with the entry's mask bits removed, equal the stored base bits 31:17. It must also have its valid bit for the current mode set: bit 1 in supervisor mode (`*_user`=0), bit 0 in user mode (`*_user`=1).
- R8: On a hit, the physical address is the lower word's bits 31:17 ORed with the effective-address bits under the mask or in bits 16:0. The protection output is lower-word bits 1:0, and the entry output is the winning entry number.
- R9: When several entries hit, the lowest-numbered one is reported.
- R10: On a miss the hit, entry, physical address and protection outputs are all zero.
- R11: A write takes effect at the clock edge that samples it. A lookup in the same cycle reports the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write command valid |
| wr_side | input | 1 | 0 instruction bank, 1 data bank |
| wr_upper | input | 1 | 1 upper word, 0 lower word |
| wr_idx | input | IDX_W (2) | Entry number |
| wr_data | input | 32 | Value to write |
| i_ea | input | 32 | Instruction-side effective address |
| i_user | input | 1 | Instruction-side mode, 1 user |
| i_hit | output | 1 | Instruction-side hit |
| i_entry | output | IDX_W (2) | Instruction-side winning entry |
| i_pa | output | 32 | Instruction-side physical address |
| i_prot | output | 2 | Instruction-side protection field |
| d_ea | input | 32 | Data-side effective address |
| d_user | input | 1 | Data-side mode, 1 user |
| d_hit | output | 1 | Data-side hit |
| d_entry | output | IDX_W (2) | Data-side winning entry |
| d_pa | output | 32 | Data-side physical address |
| d_prot | output | 2 | Data-side protection field |

## Verification
A register write and a lookup of the very entry being written can fall in the same cycle. So can an upper write and the paired lower word it rewrites. The bench drives a write together with a lookup that hits that entry. It expects the old translation in that cycle and the new one in the next. It also loads a lower word with bits under the future mask before the upper write, then checks the translated address, which shows whether the refit cleared those bits. A behavioural reference model runs alongside on random traffic and checks both lookups every cycle, so same-cycle collisions are also judged in bulk.

// File: rtl/blkxlat_pkg.sv
package blkxlat_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t LEN_SPAN    = 32'h0FFE_0000;
  localparam word_t OFS_BITS    = 32'h0001_FFFF;
  localparam word_t UP_KEEP_LO  = 32'h0000_1FFF;
  localparam word_t LO_KEEP_LO  = 32'h0000_007B;

  function automatic word_t blk_mask(input word_t up);
    return (up << 15) & LEN_SPAN;
  endfunction

  function automatic word_t upper_fold(input word_t v);
    return (v & UP_KEEP_LO) | (v & ~OFS_BITS & ~blk_mask(v));
  endfunction

  function automatic word_t lower_fold(input word_t lo, input word_t msk);
    return (lo & LO_KEEP_LO) | (lo & ~OFS_BITS & ~msk);
  endfunction

  function automatic logic base_match(input word_t up, input word_t ea);
    return (ea & ~OFS_BITS & ~blk_mask(up)) == (up & ~OFS_BITS);
  endfunction

  function automatic logic mode_valid(input word_t up, input logic user);
    return user ? up[0] : up[1];
  endfunction

  function automatic word_t translate(input word_t up, input word_t lo, input word_t ea);
    return (lo & ~OFS_BITS) | (ea & (blk_mask(up) | OFS_BITS));
  endfunction
endpackage

// File: rtl/blkxlat_bank.sv
module blkxlat_bank
  import blkxlat_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_upper,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  output word_t            upper_q [N_ENT],
  output word_t            lower_q [N_ENT]
);
  logic upper_take;
  logic lower_take;

  assign upper_take = wr_en && wr_upper && (wr_data != upper_q[wr_idx]);
  assign lower_take = wr_en && !wr_upper;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N_ENT; k++) begin
        upper_q[k] <= '0;
        lower_q[k] <= '0;
      end
    end else if (upper_take) begin
      upper_q[wr_idx] <= upper_fold(wr_data);
      lower_q[wr_idx] <= lower_fold(lower_q[wr_idx], blk_mask(wr_data));
    end else if (lower_take) begin
      lower_q[wr_idx] <= wr_data;
    end
  end

  for (genvar k = 0; k < N_ENT; k++) begin : g_chk
    // R2: lower word takes the written value verbatim
    assert_lower_verbatim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lower_take && wr_idx == IDX_W'(k)) |=> lower_q[k] == $past(wr_data));
    // R3: stored upper word carries no bits 16:13 and no masked base bits
    assert_upper_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upper_take && wr_idx == IDX_W'(k)) |=>
        ((upper_q[k] & 32'h0001_E000) == '0) && ((upper_q[k] & blk_mask(upper_q[k])) == '0));
    // R4: paired lower word loses masked bits and bits outside the keep set
    assert_lower_refit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upper_take && wr_idx == IDX_W'(k)) |=>
        ((lower_q[k] & 32'h0001_FF84) == '0) && ((lower_q[k] & blk_mask(upper_q[k])) == '0));
    // R5: rewriting the stored upper value changes nothing
    assert_same_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_upper && !upper_take && wr_idx == IDX_W'(k)) |=>
        ($stable(upper_q[k]) && $stable(lower_q[k])));
  end
endmodule

// File: rtl/blkxlat_match.sv
module blkxlat_match
  import blkxlat_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  word_t            upper [N_ENT],
  input  word_t            lower [N_ENT],
  input  word_t            ea,
  input  logic             user,
  output logic             hit,
  output logic [IDX_W-1:0] entry,
  output word_t            pa,
  output logic [1:0]       prot
);
  logic [N_ENT-1:0] ent_hit;
  logic [IDX_W-1:0] sel;

  for (genvar k = 0; k < N_ENT; k++) begin : g_ent
    assign ent_hit[k] = base_match(upper[k], ea) && mode_valid(upper[k], user);
  end

  always_comb begin
    sel = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (ent_hit[e]) sel = IDX_W'(e);
    end
  end

  assign hit   = |ent_hit;
  assign entry = hit ? sel : '0;
  assign pa    = hit ? translate(upper[sel], lower[sel], ea) : '0;
  assign prot  = hit ? lower[sel][1:0] : 2'b00;

  // R7: a reported hit always has the valid bit of the current mode
  assert_mode_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (user ? upper[entry][0] : upper[entry][1]));
  // R8: the in-block offset passes straight through
  assert_offset_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pa[16:0] == ea[16:0]);
  // R9: no lower-numbered entry also hits
  assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (ent_hit[entry] && ((ent_hit & ((N_ENT'(1) << entry) - N_ENT'(1))) == '0)));
  // R10: miss drives all result fields to zero
  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pa == '0 && prot == 2'b00 && entry == '0));
endmodule

// File: rtl/blkxlat_regs.sv
module blkxlat_regs
  import blkxlat_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_side,
  input  logic             wr_upper,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [31:0]      i_ea,
  input  logic             i_user,
  output logic             i_hit,
  output logic [IDX_W-1:0] i_entry,
  output logic [31:0]      i_pa,
  output logic [1:0]       i_prot,
  input  logic [31:0]      d_ea,
  input  logic             d_user,
  output logic             d_hit,
  output logic [IDX_W-1:0] d_entry,
  output logic [31:0]      d_pa,
  output logic [1:0]       d_prot
);
  localparam int N_SIDE = 2;

  word_t            up_q   [N_SIDE][N_ENT];
  word_t            lo_q   [N_SIDE][N_ENT];
  word_t            ea_s   [N_SIDE];
  logic             user_s [N_SIDE];
  logic             hit_s  [N_SIDE];
  logic [IDX_W-1:0] ent_s  [N_SIDE];
  word_t            pa_s   [N_SIDE];
  logic [1:0]       prot_s [N_SIDE];

  assign ea_s[0]   = i_ea;
  assign ea_s[1]   = d_ea;
  assign user_s[0] = i_user;
  assign user_s[1] = d_user;

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    logic side_wr;
    assign side_wr = wr_en && (wr_side == s[0]);

    blkxlat_bank #(.N_ENT(N_ENT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (side_wr),
      .wr_upper (wr_upper),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .upper_q  (up_q[s]),
      .lower_q  (lo_q[s])
    );

    blkxlat_match #(.N_ENT(N_ENT)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .upper (up_q[s]),
      .lower (lo_q[s]),
      .ea    (ea_s[s]),
      .user  (user_s[s]),
      .hit   (hit_s[s]),
      .entry (ent_s[s]),
      .pa    (pa_s[s]),
      .prot  (prot_s[s])
    );

    for (genvar k = 0; k < N_ENT; k++) begin : g_iso
      // R6: a write aimed at the other side leaves this side's entries alone
      assert_side_isolate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_side != s[0])) |=> ($stable(up_q[s][k]) && $stable(lo_q[s][k])));
    end
  end

  assign i_hit   = hit_s[0];
  assign i_entry = ent_s[0];
  assign i_pa    = pa_s[0];
  assign i_prot  = prot_s[0];
  assign d_hit   = hit_s[1];
  assign d_entry = ent_s[1];
  assign d_pa    = pa_s[1];
  assign d_prot  = prot_s[1];
endmodule

// File: tb/blkxlat_regs_bench.sv
`timescale 1ns/1ps
module blkxlat_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_side, wr_upper;
  logic [1:0]  wr_idx;
  logic [31:0] wr_data;
  logic [31:0] i_ea, d_ea;
  logic        i_user, d_user;
  logic        i_hit, d_hit;
  logic [1:0]  i_entry, d_entry, i_prot, d_prot;
  logic [31:0] i_pa, d_pa;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_up [2][4];
  logic [31:0] m_lo [2][4];

  always #2.5 clk = ~clk;

  blkxlat_regs u_blkxlat_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
    .i_ea(i_ea), .i_user(i_user), .i_hit(i_hit), .i_entry(i_entry),
    .i_pa(i_pa), .i_prot(i_prot),
    .d_ea(d_ea), .d_user(d_user), .d_hit(d_hit), .d_entry(d_entry),
    .d_pa(d_pa), .d_prot(d_prot)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: block length lives in bits 12:2, mask starts at bit 17
  task automatic model_write(input bit s, input bit up, input int i, input logic [31:0] v);
    logic [31:0] msk, nu, nl, old;
    if (!up) begin
      m_lo[s][i] = v;
    end else if (v != m_up[s][i]) begin
      msk = ((v >> 2) & 32'h7FF) << 17;
      old = m_lo[s][i];
      nu = v & 32'h1FFF;
      nl = 32'h0;
      foreach (nl[b]) begin
        if (b >= 17 && !msk[b]) begin
          nu[b] = v[b];
          nl[b] = old[b];
        end
        if (b == 0 || b == 1 || (b >= 3 && b <= 6)) nl[b] = old[b];
      end
      m_up[s][i] = nu;
      m_lo[s][i] = nl;
    end
  endtask

  task automatic model_look(input bit s, input logic [31:0] ea, input bit user,
                            output bit hit, output int idx, output logic [31:0] pa, output logic [1:0] prot);
    hit = 0; idx = 0; pa = 0; prot = 0;
    for (int e = 0; e < 4; e++) begin
      logic [31:0] u, l, msk;
      bit ok;
      if (hit) break;
      u = m_up[s][e];
      l = m_lo[s][e];
      msk = ((u >> 2) & 32'h7FF) << 17;
      ok = user ? u[0] : u[1];
      for (int b = 17; b < 32; b++) if (!msk[b] && ea[b] != u[b]) ok = 0;
      if (ok) begin
        hit = 1; idx = e; prot = l[1:0];
        for (int b = 0; b < 32; b++)
          pa[b] = (b >= 17 && l[b]) || ((b < 17 || msk[b]) && ea[b]);
      end
    end
  endtask

  task automatic cmp_side(input bit s, input string req);
    bit h; int ix; logic [31:0] p; logic [1:0] pr;
    model_look(s, s ? d_ea : i_ea, s ? d_user : i_user, h, ix, p, pr);
    checks++;
    if ((s ? d_hit : i_hit) !== h || (s ? d_entry : i_entry) !== 2'(ix) ||
        (s ? d_pa : i_pa) !== p || (s ? d_prot : i_prot) !== pr) begin
      errors++;
      $display("FAIL %s side%0d actual hit=%b ent=%0d pa=%h prot=%0d expected hit=%b ent=%0d pa=%h prot=%0d",
               req, s, s ? d_hit : i_hit, s ? d_entry : i_entry, s ? d_pa : i_pa, s ? d_prot : i_prot,
               h, ix, p, pr);
    end
  endtask

  // drive one cycle: compare before the edge (old contents), then advance the model
  task automatic step(input bit we, input bit ws, input bit wu, input int wi, input logic [31:0] wd,
                      input logic [31:0] iea, input bit iu, input logic [31:0] dea, input bit du,
                      input string req);
    @(negedge clk);
    wr_en = we; wr_side = ws; wr_upper = wu; wr_idx = 2'(wi); wr_data = wd;
    i_ea = iea; i_user = iu; d_ea = dea; d_user = du;
    #1;
    cmp_side(0, req);
    cmp_side(1, req);
    if (we) model_write(ws, wu, wi, wd);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) for (int i = 0; i < 4; i++) begin m_up[s][i] = 0; m_lo[s][i] = 0; end
    rst_n = 0; wr_en = 0; wr_side = 0; wr_upper = 0; wr_idx = 0; wr_data = 0;
    i_ea = 0; i_user = 0; d_ea = 0; d_user = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state, nothing hits
    step(0,0,0,0,0, 32'h0000_0000,0, 32'h0000_0000,0, "R1");
    chk("R1", "i_hit", {31'b0, i_hit}, 0);
    chk("R1", "d_hit", {31'b0, d_hit}, 0);

    // R2 / R8: simple 128 KB block on data side entry 0
    step(1,1,0,0, 32'h2000_0002, 0,0, 0,0, "R2");
    step(1,1,1,0, 32'h1000_0003, 0,0, 0,0, "R3");
    step(0,0,0,0,0, 32'h1000_1234,0, 32'h1000_1234,0, "R8");
    chk("R8", "d_hit", {31'b0, d_hit}, 1);
    chk("R8", "d_pa", d_pa, 32'h2000_1234);
    chk("R8", "d_prot", {30'b0, d_prot}, 2);
    chk("R6", "i_hit", {31'b0, i_hit}, 0);

    // R7: supervisor-only entry 2
    step(1,1,1,2, 32'h5000_0002, 0,0, 0,0, "R7");
    step(1,1,0,2, 32'h6000_0001, 0,0, 0,0, "R7");
    step(0,0,0,0,0, 0,0, 32'h5000_0010,1, "R7");
    chk("R7", "user miss", {31'b0, d_hit}, 0);
    step(0,0,0,0,0, 0,0, 32'h5000_0010,0, "R7");
    chk("R7", "super entry", {30'b0, d_entry}, 2);
    chk("R7", "super pa", d_pa, 32'h6000_0010);

    // R4: 4 MB block on entry 1, lower loaded first with bits under the mask
    step(1,1,0,1, 32'h3456_78FF, 0,0, 0,0, "R4");
    step(1,1,1,1, 32'h4000_007F, 0,0, 0,0, "R4");
    step(0,0,0,0,0, 0,0, 32'h403F_FFFC,1, "R4");
    chk("R4", "entry", {30'b0, d_entry}, 1);
    chk("R4", "pa", d_pa, 32'h347F_FFFC);
    chk("R4", "prot", {30'b0, d_prot}, 3);
    step(0,0,0,0,0, 0,0, 32'h4040_0000,1, "R7");
    chk("R7", "outside block", {31'b0, d_hit}, 0);

    // R3: base bit under the mask is dropped, so the block still matches
    step(1,1,1,3, 32'h7032_0007, 0,0, 0,0, "R3");
    step(0,0,0,0,0, 0,0, 32'h7031_0005,0, "R3");
    chk("R3", "hit", {31'b0, d_hit}, 1);
    chk("R3", "pa", d_pa, 32'h0001_0005);

    // R5: same upper value again does not refit the lower word
    step(1,1,0,1, 32'h0FFF_FFFF, 0,0, 0,0, "R5");
    step(1,1,1,1, 32'h4000_007F, 0,0, 0,0, "R5");
    step(0,0,0,0,0, 0,0, 32'h4000_0000,1, "R5");
    chk("R5", "pa", d_pa, 32'h0FFE_0000);
    chk("R5", "prot", {30'b0, d_prot}, 3);

    // R9: entry 3 moved onto entry 0's block, entry 0 wins
    step(1,1,1,3, 32'h1000_0003, 0,0, 0,0, "R9");
    step(1,1,0,3, 32'h9000_0001, 0,0, 0,0, "R9");
    step(0,0,0,0,0, 0,0, 32'h1000_0000,0, "R9");
    chk("R9", "entry", {30'b0, d_entry}, 0);
    chk("R9", "pa", d_pa, 32'h2000_0000);

    // R11: write and lookup of the same entry in one cycle
    step(1,1,0,0, 32'hA000_0003, 0,0, 32'h1000_0000,0, "R11");
    chk("R11", "old pa", d_pa, 32'h2000_0000);
    step(0,0,0,0,0, 0,0, 32'h1000_0000,0, "R11");
    chk("R11", "new pa", d_pa, 32'hA000_0000);

    // R6: instruction side programmed, data side untouched
    step(1,0,1,0, 32'h1000_0003, 0,0, 0,0, "R6");
    step(1,0,0,0, 32'h3000_0001, 0,0, 0,0, "R6");
    step(0,0,0,0,0, 32'h1000_0000,0, 32'h1000_0000,0, "R6");
    chk("R6", "i_pa", i_pa, 32'h3000_0000);
    chk("R6", "d_pa", d_pa, 32'hA000_0000);

    // R10: miss zeroes every field
    step(0,0,0,0,0, 32'hF000_0000,0, 32'hF000_0000,0, "R10");
    chk("R10", "pa", d_pa, 0);
    chk("R10", "prot", {30'b0, d_prot}, 0);
    chk("R10", "entry", {30'b0, d_entry}, 0);

    // R8 random traffic against the reference model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] bases [4];
      logic [31:0] wd, ie, de;
      bases[0] = 32'h1000_0000; bases[1] = 32'h4000_0000;
      bases[2] = 32'h4060_0000; bases[3] = 32'h8000_0000;
      wd = ($urandom % 2) ? (bases[$urandom % 4] | ($urandom & 32'h003F_FFFF) | ($urandom & 32'h1FFF))
                          : $urandom;
      ie = bases[$urandom % 4] | ($urandom & 32'h007F_FFFF);
      de = bases[$urandom % 4] | ($urandom & 32'h007F_FFFF);
      step(($urandom % 2) == 0, $urandom % 2, $urandom % 2, $urandom % 4, wd,
           ie, $urandom % 2, de, $urandom % 2, "R8");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule